// File: doc/BRIEF.md
# Countdown Watchdog with APB Register Access

This block is a watchdog built around a 32-bit down-counter. It is programmed over an APB slave port. The counter moves only on cycles where the `tick` strobe is high and counting is enabled. An external divider owns the tick rate and may change it at any time. Each tick that takes the counter to zero sets a raw interrupt flag. The next tick reloads the counter from the programmed load value.

Software services the watchdog by writing anything to the clear register. That write drops the flag and restarts the count. If software does not clear the flag before the counter runs out a second time, and reset generation is enabled, the block pulses a reset request. A key-protected lock guards the configuration and clear registers against stray writes.

Top module: `wdt_apb`

## Requirements
- R1: After reset, the load register and the counter both read 0xFFFFFFFF. Control reads 0, the raw flag reads 0, the lock register reads 0 (unlocked), and `irq` and `rst_req` are low.
- R2: A write to the load register at byte offset 0x000 sets both the load value and the counter. Counter reads come from offset 0x004. The counter falls by one in each cycle where `tick` is high and control bit 0 is 1. It holds when `tick` is low or control bit 0 is 0.
- R3: The tick that brings the counter to 0 sets the raw flag, which reads as bit 0 of offset 0x010. From then on the counter reads 0.
- R4: The tick after the counter has reached 0 reloads it with the load value, and counting carries on from there.
- R5: A write of any data to the clear register at offset 0x00C drops the raw flag and reloads the counter from the load value in the same cycle.
- R6: The control register is at offset 0x008. The masked status at offset 0x014 reads the raw flag ANDed with control bit 0. The `irq` output equals the masked status.
- R7: Control bit 1 enables reset generation. When the counter reaches 0 while the raw flag is already set, and control bits 1 and 0 are both 1, `rst_req` goes high for exactly one clock cycle.
- R8: The lock register is at offset 0xC00. Writing 0x1ACCE551 to it unlocks the block, and any other value locks it. It reads 1 when locked and 0 when unlocked. While the block is locked, writes to load, control and clear have no effect.
- R9: Reads of any other offset, or of an offset that is not a multiple of 4, return 0, and writes to such offsets change nothing. `pready` is always 1 and `pslverr` is always 0.
- R10: Counting depends only on the number of tick pulses, not on how far apart they are. Spaced ticks and back-to-back ticks each take exactly one off the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| tick | input | 1 | Count enable strobe from the external divider |
| irq | output | 1 | Masked interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The counting path is tried with single spaced tick pulses, with ticks spread several cycles apart, and with ticks held high for many cycles in a row. Together these show that the count follows pulse count alone (R10), and they would expose a decrement that was missed or doubled. The run to zero is followed by a further tick and then by a clear write part way through a count. This separates the reload on the following tick from the immediate reload on a clear. The second expiry is tested with the flag left set and with it cleared, so that a reset request tied to the flag is distinguished from one that fires on every expiry. Lock checks compare a locked write with the same write after unlocking.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Byte offsets of the programming registers
    localparam int OFF_LOAD  = 'h000;
    localparam int OFF_COUNT = 'h004;
    localparam int OFF_CTRL  = 'h008;
    localparam int OFF_CLR   = 'h00C;
    localparam int OFF_RAW   = 'h010;
    localparam int OFF_MASK  = 'h014;
    localparam int OFF_LOCK  = 'hC00;

    // Value that opens the lock
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

    // One write strobe per writable register
    typedef struct packed {
        logic load;
        logic ctrl;
        logic clr;
        logic lock;
    } wr_strb_t;

endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] load_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic [1:0]        ctrl_i,
    input  logic              raw_i,
    input  logic              locked_i,
    output wr_strb_t          wr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              wr_en;
    logic              hit_load, hit_count, hit_ctrl, hit_clr;
    logic              hit_raw, hit_mask, hit_lock, hit_any;

    assign word    = paddr[ADDR_W-1:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign wr_en   = psel && penable && pwrite;

    always_comb begin
        hit_load  = aligned && (word == WORD_W'(OFF_LOAD  >> 2));
        hit_count = aligned && (word == WORD_W'(OFF_COUNT >> 2));
        hit_ctrl  = aligned && (word == WORD_W'(OFF_CTRL  >> 2));
        hit_clr   = aligned && (word == WORD_W'(OFF_CLR   >> 2));
        hit_raw   = aligned && (word == WORD_W'(OFF_RAW   >> 2));
        hit_mask  = aligned && (word == WORD_W'(OFF_MASK  >> 2));
        hit_lock  = aligned && (word == WORD_W'(OFF_LOCK  >> 2));
        hit_any   = hit_load | hit_count | hit_ctrl | hit_clr |
                    hit_raw | hit_mask | hit_lock;

        wr_o.load = wr_en && hit_load;
        wr_o.ctrl = wr_en && hit_ctrl;
        wr_o.clr  = wr_en && hit_clr;
        wr_o.lock = wr_en && hit_lock;

        rdata_o = '0;
        if (hit_load)  rdata_o = load_i;
        if (hit_count) rdata_o = count_i;
        if (hit_ctrl)  rdata_o = DATA_W'(ctrl_i);
        if (hit_raw)   rdata_o = DATA_W'(raw_i);
        if (hit_mask)  rdata_o = DATA_W'(raw_i & ctrl_i[0]);
        if (hit_lock)  rdata_o = DATA_W'(locked_i);
    end

    // R9: an unmapped or misaligned address never returns data
    always_comb begin
        if (!hit_any) a_r9_unmapped_zero: assert (rdata_o == '0);
    end

endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strb_t          wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] load_o,
    output logic [1:0]        ctrl_o,
    output logic              locked_o,
    output logic              ld_ok_o,
    output logic              clr_ok_o
);

    typedef struct packed {
        logic [DATA_W-1:0] load;
        logic [1:0]        ctrl;
        logic              locked;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i.lock) cfg_d.locked = (wdata_i != DATA_W'(UNLOCK_KEY));
        if (!cfg_q.locked) begin
            if (wr_i.load) cfg_d.load = wdata_i;
            if (wr_i.ctrl) cfg_d.ctrl = wdata_i[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{load: '1, ctrl: 2'b00, locked: 1'b0};
        else        cfg_q <= cfg_d;
    end

    assign load_o   = cfg_q.load;
    assign ctrl_o   = cfg_q.ctrl;
    assign locked_o = cfg_q.locked;
    assign ld_ok_o  = wr_i.load && !cfg_q.locked;
    assign clr_ok_o = wr_i.clr  && !cfg_q.locked;

    // R8: a locked block keeps its load and control values
    a_r8_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.locked && !wr_i.lock |=> $stable(cfg_q.load) && $stable(cfg_q.ctrl));

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              rst_en_i,
    input  logic              ld_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] load_i,
    output logic [DATA_W-1:0] count_o,
    output logic              raw_o,
    output logic              rreq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic              raw;
        logic              rreq;
    } core_t;

    core_t             st_d, st_q;
    logic [DATA_W-1:0] stepped;
    logic              step;
    logic              hit_zero;

    always_comb begin
        step     = tick_i && en_i;
        stepped  = (st_q.count == '0) ? load_i : st_q.count - 1'b1;
        hit_zero = step && (stepped == '0) && !ld_i && !clr_i;

        st_d      = st_q;
        st_d.rreq = 1'b0;

        if (ld_i)       st_d.count = wdata_i;
        else if (clr_i) st_d.count = load_i;
        else if (step)  st_d.count = stepped;

        if (clr_i)         st_d.raw = 1'b0;
        else if (hit_zero) st_d.raw = 1'b1;

        st_d.rreq = hit_zero && st_q.raw && rst_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{count: '1, raw: 1'b0, rreq: 1'b0};
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign raw_o   = st_q.raw;
    assign rreq_o  = st_q.rreq;

    // R2: no tick and no write leaves the counter where it is
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !ld_i && !clr_i |=> $stable(st_q.count));

    // R3: stepping from one lands on zero with the flag up
    a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && en_i && !ld_i && !clr_i && st_q.count == 1 |=> st_q.raw && st_q.count == '0);

    // R4: stepping from zero reloads
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && en_i && !ld_i && !clr_i && st_q.count == '0 |=> st_q.count == $past(load_i));

    // R5: clear drops the flag and restarts the count
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !ld_i |=> !st_q.raw && st_q.count == $past(load_i));

    // R7: a reset request only follows an expiry with the flag already set
    a_r7_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rreq) |-> $past(st_q.raw) && $past(rst_en_i));

endmodule

// File: rtl/wdt_apb.sv
module wdt_apb
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick,
    output logic              irq,
    output logic              rst_req
);

    wr_strb_t          wr;
    logic [DATA_W-1:0] load_v, count_v;
    logic [1:0]        ctrl_v;
    logic              locked_v, ld_ok, clr_ok, raw_v;

    wdt_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .load_i   (load_v),
        .count_i  (count_v),
        .ctrl_i   (ctrl_v),
        .raw_i    (raw_v),
        .locked_i (locked_v),
        .wr_o     (wr),
        .rdata_o  (prdata)
    );

    wdt_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr),
        .wdata_i  (pwdata),
        .load_o   (load_v),
        .ctrl_o   (ctrl_v),
        .locked_o (locked_v),
        .ld_ok_o  (ld_ok),
        .clr_ok_o (clr_ok)
    );

    wdt_core #(.DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .en_i     (ctrl_v[0]),
        .rst_en_i (ctrl_v[1]),
        .ld_i     (ld_ok),
        .clr_i    (clr_ok),
        .wdata_i  (pwdata),
        .load_i   (load_v),
        .count_o  (count_v),
        .raw_o    (raw_v),
        .rreq_o   (rst_req)
    );

    assign irq     = raw_v && ctrl_v[0];
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: tb/wdt_apb_test.sv
`timescale 1ns/1ps
module wdt_apb_test;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;   // write data, tick count, or expected read
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 12'hC00, 32'h0,          4'd1},  // R1 unlocked
        '{OP_RD, 12'h000, 32'hFFFF_FFFF,  4'd1},  // R1 load
        '{OP_RD, 12'h004, 32'hFFFF_FFFF,  4'd1},  // R1 counter
        '{OP_RD, 12'h008, 32'h0,          4'd1},  // R1 control
        '{OP_RD, 12'h010, 32'h0,          4'd1},  // R1 flag
        '{OP_WR, 12'h008, 32'h1,          4'd2},
        '{OP_WR, 12'h000, 32'd10,         4'd2},
        '{OP_RD, 12'h004, 32'd10,         4'd2},  // R2 load sets counter
        '{OP_TK, 12'h000, 32'd4,          4'd2},
        '{OP_RD, 12'h004, 32'd6,          4'd2},  // R2 decrement
        '{OP_RD, 12'h010, 32'h0,          4'd3},  // R3 flag low above zero
        '{OP_TK, 12'h000, 32'd6,          4'd3},
        '{OP_RD, 12'h004, 32'd0,          4'd3},  // R3 counter at zero
        '{OP_RD, 12'h010, 32'h1,          4'd3},  // R3 flag set
        '{OP_RD, 12'h014, 32'h1,          4'd6},  // R6 masked
        '{OP_TK, 12'h000, 32'd1,          4'd4},
        '{OP_RD, 12'h004, 32'd10,         4'd4},  // R4 reload
        '{OP_TK, 12'h000, 32'd3,          4'd4},
        '{OP_RD, 12'h004, 32'd7,          4'd4},  // R4 counting resumes
        '{OP_WR, 12'h00C, 32'hDEAD_BEEF,  4'd5},
        '{OP_RD, 12'h004, 32'd10,         4'd5},  // R5 reload on clear
        '{OP_RD, 12'h010, 32'h0,          4'd5},  // R5 flag cleared
        '{OP_RD, 12'h018, 32'h0,          4'd9},  // R9 unmapped
        '{OP_RD, 12'h001, 32'h0,          4'd9},  // R9 misaligned
        '{OP_RD, 12'hC04, 32'h0,          4'd9}   // R9 unmapped near lock
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tick = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq, rst_req;

    int n_run = 0;
    int n_fail = 0;
    int rq_cnt = 0;

    always #2 clk = ~clk;

    wdt_apb uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .tick(tick), .irq(irq),
        .rst_req(rst_req)
    );

    always @(negedge clk) if (rst_req) rq_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // gap 0: tick held high for n cycles; otherwise single pulses gap cycles apart
    task automatic ticks(input int n, input int gap);
        if (gap == 0) begin
            @(negedge clk); tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end else begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk); tick = 1'b1;
                @(negedge clk); tick = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        apb_rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR: apb_wr(VEC[i].addr, VEC[i].data);
                OP_TK: ticks(int'(VEC[i].data), 1);
                default: begin
                    apb_rd(VEC[i].addr, v);
                    chk($sformatf("R%0d vec %0d", VEC[i].req, i), v, VEC[i].data);
                end
            endcase
        end

        // R9: bus response and ignored writes
        chk("R9 pready", {31'b0, pready}, 32'h1);
        chk("R9 pslverr", {31'b0, pslverr}, 32'h0);
        apb_wr(12'h020, 32'h5);
        apb_wr(12'h001, 32'h7);
        rd_chk("R9 stray writes", 12'h000, 32'd10);

        // R6: mask follows control bit 0
        apb_wr(12'h000, 32'd2);
        ticks(2, 1);
        chk("R6 irq on", {31'b0, irq}, 32'h1);
        apb_wr(12'h008, 32'h0);
        rd_chk("R6 masked off", 12'h014, 32'h0);
        rd_chk("R6 raw kept", 12'h010, 32'h1);
        chk("R6 irq off", {31'b0, irq}, 32'h0);
        ticks(3, 1);
        rd_chk("R2 disabled hold", 12'h004, 32'h0);

        // R7: reset request only on the second expiry
        apb_wr(12'h008, 32'h3);
        apb_wr(12'h00C, 32'h0);
        apb_wr(12'h000, 32'd3);
        rq_cnt = 0;
        ticks(3, 1);
        rd_chk("R7 first expiry flag", 12'h010, 32'h1);
        chk("R7 no request yet", rq_cnt, 0);
        ticks(4, 1);
        chk("R7 one pulse", rq_cnt, 1);
        apb_wr(12'h008, 32'h1);

        // R10: mixed tick spacing
        apb_wr(12'h00C, 32'h0);
        apb_wr(12'h000, 32'd20);
        ticks(6, 4);
        rd_chk("R10 slow ticks", 12'h004, 32'd14);
        ticks(6, 0);
        rd_chk("R10 fast ticks", 12'h004, 32'd8);
        ticks(8, 0);
        rd_chk("R10 drained", 12'h004, 32'd0);
        rd_chk("R10 flag", 12'h010, 32'h1);

        // R8: locking
        apb_wr(12'hC00, 32'h0);
        rd_chk("R8 locked", 12'hC00, 32'h1);
        apb_wr(12'h000, 32'd5);
        rd_chk("R8 load ignored", 12'h000, 32'd20);
        apb_wr(12'h008, 32'h0);
        rd_chk("R8 control ignored", 12'h008, 32'h1);
        apb_wr(12'h00C, 32'h0);
        rd_chk("R8 clear ignored", 12'h010, 32'h1);
        apb_wr(12'hC00, 32'h1ACC_E551);
        rd_chk("R8 unlocked", 12'hC00, 32'h0);
        apb_wr(12'h000, 32'd5);
        rd_chk("R8 load accepted", 12'h000, 32'd5);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule